// File: doc/BRIEF.md
# Write-Busy Status Byte Generator

This block supplies the byte a memory device places on its data pins while an internal program or erase cycle is running. A write is launched by a legal combination of the three active-low strobes (chip enable, write enable, output enable). When a write launches, the block captures the byte being loaded and starts an internal down-counter that holds a busy flag high for a fixed number of clock cycles. The strobes are sampled on the block clock.

While the busy flag is high, every read returns a status byte instead of array contents. The top bit is the inverse of the top bit of the captured byte. The next bit flips on each new read and is cleared when a write launches. The remaining low bits read as zero. Once the counter expires, reads return the true array byte from the `arr_data` input. Software can therefore detect completion in three ways: by watching the top bit turn true, by seeing the toggle bit stop, or by getting two identical reads in a row.

Top module: `wsr_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `dq_out` is 8'h00 and both `dq_drive` and `wr_busy` are 0.
- R2: A write launches on the first clock edge at which `ce_n`=0, `we_n`=0 and `oe_n`=1 hold after any other combination. `wr_busy` reads 1 for exactly `CYCLES` consecutive cycles, starting in the cycle after that edge.
- R3: No write launches while `oe_n`=0, `ce_n`=1 or `we_n`=1; `wr_busy` stays 0.
- R4: A read that begins while busy returns bit 7 of `dq_out` equal to the inverse of bit 7 of the byte captured from `din` at launch.
- R5: Bit 6 of the busy status byte is 0 on the first read after a write launches and alternates on each following read, whatever value it had during the previous write.
- R6: Bits 5 to 0 of the busy status byte are 0.
- R7: A read that begins while `wr_busy` is 0 returns `arr_data` unchanged, including bits 7 and 6.
- R8: A write combination that arrives while busy is ignored: the captured byte and the remaining busy time are unchanged.
- R9: Reads during a write do not shorten or lengthen the busy period.
- R10: A read begins on the first edge at which `ce_n`=0, `oe_n`=0 and `we_n`=1 hold. From the next cycle `dq_drive` is 1 and `dq_out` holds the read result. `dq_drive` drops in the cycle after the read combination ends.
- R11: After completion, two successive reads of an unchanged array byte return identical values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| din | input | 8 | Byte being loaded by a write |
| arr_data | input | 8 | True array byte for the current address |
| dq_out | output | 8 | Byte presented to the data bus |
| dq_drive | output | 1 | High while a read is driving the bus |
| wr_busy | output | 1 | High while the internal write cycle runs |

## Verification
The hardest case to reach is a new write that launches while the toggle bit was left at 1 by the previous write. The stimulus table therefore gives one row an odd number of busy reads, and the next row checks that its first read shows bit 6 at 0. A second hard case is a write attempt during a busy period. A directed test issues one right after a launch with the opposite top bit. It then confirms that the polled bit still follows the first byte and that the busy period still lasts exactly `CYCLES` cycles.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    localparam int DQ_W     = 8;
    localparam int POLL_BIT = DQ_W - 1;
    localparam int TGL_BIT  = DQ_W - 2;

    typedef logic [DQ_W-1:0] dq_t;

    typedef struct packed {
        logic wr_prev;
        logic rd_prev;
    } strobe_st_t;

    typedef struct packed {
        dq_t  ld;
        logic tgl;
        dq_t  dq;
    } status_st_t;
endpackage

// File: rtl/wsr_timer.sv
module wsr_timer #(
    parameter int unsigned CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_st_t;

    timer_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt = CNT_W'(CYCLES);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);

    // R2: a launch always raises busy on the next cycle
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R9: once running, the count only ever steps down by one
    a_r9_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |=> (st_q.cnt == CNT_W'($past(st_q.cnt) - 1'b1)));

    // R2: count never exceeds the configured duration
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(CYCLES));
endmodule

// File: rtl/wsr_strobe.sv
module wsr_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_start,
    output logic rd_start,
    output logic rd_live
);
    import wsr_pkg::*;

    strobe_st_t st_d, st_q;
    logic       wr_cond;
    logic       rd_cond;

    always_comb begin
        wr_cond    = !ce_n && !we_n && oe_n;
        rd_cond    = !ce_n && !oe_n && we_n;
        wr_start   = wr_cond && !st_q.wr_prev;
        rd_start   = rd_cond && !st_q.rd_prev;
        st_d       = st_q;
        st_d.wr_prev = wr_cond;
        st_d.rd_prev = rd_cond;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_live = st_q.rd_prev;

    // R10: a read start drives the bus on the following cycle
    a_r10_drive_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> rd_live);

    // R10: drive drops once the read combination is gone
    a_r10_drive_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n) |=> !rd_live);
endmodule

// File: rtl/wsr_status.sv
module wsr_status (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic          busy,
    input  logic          rd_start,
    input  wsr_pkg::dq_t  din,
    input  wsr_pkg::dq_t  arr_data,
    output wsr_pkg::dq_t  dq
);
    import wsr_pkg::*;

    status_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_go) begin
            st_d.ld  = din;
            st_d.tgl = 1'b0;
        end
        if (rd_start) begin
            if (busy) begin
                st_d.dq           = '0;
                st_d.dq[POLL_BIT] = ~st_q.ld[POLL_BIT];
                st_d.dq[TGL_BIT]  = st_q.tgl;
                st_d.tgl          = ~st_q.tgl;
            end else begin
                st_d.dq = arr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq = st_q.dq;

    // R4: polled bit is the inverse of the captured byte's top bit
    a_r4_poll_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && busy) |=> (dq[POLL_BIT] == ~st_q.ld[POLL_BIT]));

    // R5: toggle state changes on every busy read
    a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && busy) |=> (st_q.tgl != $past(st_q.tgl)));

    // R6: low status bits stay clear while busy
    a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && busy) |=> (dq[TGL_BIT-1:0] == '0));

    // R7: idle reads pass array data through
    a_r7_true_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !busy) |=> (dq == $past(arr_data)));

    // R8: captured byte is frozen while a write runs
    a_r8_hold_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.ld));
endmodule

// File: rtl/wsr_top.sv
module wsr_top #(
    parameter int unsigned CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic [7:0] din,
    input  logic [7:0] arr_data,
    output logic [7:0] dq_out,
    output logic       dq_drive,
    output logic       wr_busy
);
    import wsr_pkg::*;

    logic wr_start;
    logic rd_start;
    logic rd_live;
    logic busy;
    logic wr_go;
    dq_t  dq;

    wsr_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .wr_start (wr_start),
        .rd_start (rd_start),
        .rd_live  (rd_live)
    );

    // R8: a write combination during a busy period is dropped
    assign wr_go = wr_start && !busy;

    wsr_timer #(.CYCLES(CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_go),
        .busy  (busy)
    );

    wsr_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go),
        .busy     (busy),
        .rd_start (rd_start),
        .din      (din),
        .arr_data (arr_data),
        .dq       (dq)
    );

    assign dq_out   = dq;
    assign dq_drive = rd_live;
    assign wr_busy  = busy;

    // R3: a launch only ever follows the legal strobe combination
    a_r3_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> (!ce_n && !we_n && oe_n));

    // R8: busy cannot be re-armed from within a busy period
    a_r8_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ce_n && !we_n && oe_n) |-> !wr_go);
endmodule

// File: tb/wsr_top_bench.sv
module wsr_top_bench;
    localparam int unsigned CYCLES = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       we_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] dq_out;
    logic       dq_drive;
    logic       wr_busy;

    int tests = 0;
    int fails = 0;
    int busy_run = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wsr_top #(.CYCLES(CYCLES)) u_wsr_top (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .din(din), .arr_data(arr_data), .dq_out(dq_out),
        .dq_drive(dq_drive), .wr_busy(wr_busy)
    );

    always @(negedge clk) if (wr_busy) busy_run++;

    // rows: loaded byte, array byte, number of busy reads
    localparam logic [19:0] VEC [4] = '{
        {8'h80, 8'h5A, 4'd3},
        {8'h7F, 8'hA5, 4'd4},
        {8'hFF, 8'h00, 4'd1},
        {8'h01, 8'hFF, 4'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] b);
        din = b; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic do_read(output logic [7:0] v, output logic drv);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        v = dq_out; drv = dq_drive;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && wr_busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2, exp;
        logic drv;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dq_out == 8'h00 && !dq_drive && !wr_busy, "R1 reset", {dq_out, dq_drive, wr_busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dq_out == 8'h00 && !dq_drive && !wr_busy, "R1 after release", {dq_out, dq_drive, wr_busy}, 0);

        // table walk
        for (int r = 0; r < 4; r++) begin
            logic [7:0] ld, arr;
            int n;
            ld = VEC[r][19:12]; arr = VEC[r][11:4]; n = int'(VEC[r][3:0]);
            arr_data = arr;
            busy_run = 0;
            do_write(ld);
            chk(wr_busy == 1'b1, "R2 busy after launch", wr_busy, 1);
            for (int k = 0; k < n; k++) begin
                do_read(v, drv);
                exp = {~ld[7], 1'(k % 2), 6'b0};
                chk(drv == 1'b1, "R10 drive during read", drv, 1);
                chk(v[7] == exp[7], "R4 polled bit", v[7], exp[7]);
                chk(v[6] == exp[6], "R5 toggle bit", v[6], exp[6]);
                chk(v[5:0] == 6'b0, "R6 low bits", v[5:0], 0);
                chk(dq_drive == 1'b0, "R10 drive release", dq_drive, 0);
            end
            wait_idle();
            chk(busy_run == int'(CYCLES), "R9 busy length with reads", busy_run, CYCLES);
            do_read(v, drv);
            do_read(v2, drv);
            chk(v == arr, "R7 true data after completion", v, arr);
            chk(v == v2, "R11 two reads equal", v2, v);
        end

        // R2 exact duration without reads
        busy_run = 0;
        do_write(8'h33);
        wait_idle();
        chk(busy_run == int'(CYCLES), "R2 busy length", busy_run, CYCLES);

        // R3 inhibit: output enable low
        arr_data = 8'hC3;
        din = 8'h11; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        chk(wr_busy == 1'b0, "R3 oe low inhibits", wr_busy, 0);
        // R3 inhibit: chip enable high
        ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        chk(wr_busy == 1'b0, "R3 ce high inhibits", wr_busy, 0);
        do_read(v, drv);
        chk(v == 8'hC3, "R3 read after inhibited write", v, 8'hC3);

        // R8 write during busy ignored
        busy_run = 0;
        do_write(8'h00);
        @(negedge clk);
        do_write(8'h80);
        @(negedge clk);
        do_read(v, drv);
        chk(v[7] == 1'b1, "R8 polled bit keeps first byte", v[7], 1);
        chk(v[6] == 1'b0, "R8 toggle not reset by ignored write", v[6], 0);
        wait_idle();
        chk(busy_run == int'(CYCLES), "R8 busy not extended", busy_run, CYCLES);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule